// File: doc/BRIEF.md
# Erase-then-program sequencer for a many-time programmable byte flash

This block runs a whole programming job on a byte-wide, electrically erasable flash part through that part's control pins. The host starts a job with a one-cycle start pulse. The sequencer then erases the whole chip with one long strobe pulse and reads back every address to confirm the erased value. Only after that read-back passes does it accept image bytes. Each byte arrives on a valid/ready stream together with its address and a last marker. Each byte gets a short program pulse followed by a read-back. If the byte reads back wrong, the pulse is repeated until a set limit is reached.

A second command reads the two identification bytes. It raises the high-voltage flag on address bit 9 and reads addresses 0 and 1. The sequencer does not generate any voltages. It only outputs flags that tell the external supply which pins to lift. Pulse widths and the read access delay are counted in clock cycles and are set by parameters.

Top module: `mtp_prog_seq`

## Requirements
- R1: After synchronous reset the sequencer is idle. busy, done, erase_fail, prog_fail and img_ready are low. fl_ce_n, fl_oe_n and fl_pgm_n are high, and both high-voltage flags are low.
- R2: A job command (cmd_op = 0) starts with exactly one erase pulse. fl_pgm_n is held low for exactly ERASE_CYC consecutive cycles while fl_vpp_hi and fl_a9_hi are high, fl_ce_n is low and fl_oe_n is high.
- R3: After the erase pulse, every address is read in ascending order from 0 to 2^AW-1 with both high-voltage flags low and fl_ce_n and fl_oe_n low. Each read samples fl_din at the end of the ACC_CYC-th cycle with a stable address. img_ready stays low until all of these reads have returned all-ones.
- R4: The first address whose erase read-back is not all-ones ends the job. erase_fail goes high, fail_addr holds that address and done goes high. No further address is read and no program pulse is issued.
- R5: img_ready is high only while a job is waiting for the next image byte. A byte is taken on a cycle where img_valid and img_ready are both high.
- R6: Each program pulse holds fl_pgm_n low for exactly PROG_CYC cycles. During the pulse fl_vpp_hi is high, fl_a9_hi is low, fl_ce_n is low and fl_oe_n is high, and fl_addr and fl_dout carry the byte that was taken.
- R7: fl_vpp_hi, fl_a9_hi, fl_ce_n and fl_oe_n take their pulse values at least one cycle before fl_pgm_n falls and keep them for at least one cycle after it rises. fl_addr and fl_dout do not change while fl_pgm_n is low.
- R8: After each program pulse the byte is read back. On a mismatch a new pulse is issued, up to MAX_PULSES pulses in total for that byte. If the read-back still differs after the last pulse, prog_fail goes high with fail_addr set to the byte's address.
- R9: When the byte taken with img_last set reads back correctly, done goes high and busy goes low, with both fail flags low.
- R10: An identify command (cmd_op = 1) issues no strobe. It raises fl_a9_hi with fl_vpp_hi low, reads address 0 into id_mfr and then address 1 into id_dev, and then sets done.
- R11: cmd_start is ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_start | input | 1 | One-cycle command pulse, taken only when idle |
| cmd_op | input | 1 | 0 = erase and program job, 1 = identify |
| img_valid | input | 1 | Image byte available |
| img_addr | input | AW | Address of image byte |
| img_data | input | DW | Image byte value |
| img_last | input | 1 | Marks the final image byte |
| img_ready | output | 1 | Sequencer can take an image byte |
| busy | output | 1 | Command in progress |
| done | output | 1 | Last command finished, held until next start |
| erase_fail | output | 1 | Erase read-back found a non-erased byte |
| prog_fail | output | 1 | Byte did not verify within the pulse limit |
| fail_addr | output | AW | Address of the failing byte |
| id_mfr | output | DW | Identification byte read at address 0 |
| id_dev | output | DW | Identification byte read at address 1 |
| fl_vpp_hi | output | 1 | Request high voltage on programming supply |
| fl_a9_hi | output | 1 | Request high voltage on address bit 9 |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_pgm_n | output | 1 | Program/erase strobe, active low |
| fl_addr | output | AW | Flash address |
| fl_dout | output | DW | Data driven to flash for programming |
| fl_din | input | DW | Data read from flash |

## Verification
The bench builds the sequencer with AW=4, ERASE_CYC=24, PROG_CYC=6, ACC_CYC=3 and MAX_PULSES=3. With these values the full 16-address erase read-back finishes in a few dozen cycles, so the gating of img_ready and an erase failure partway through the array can be checked on every run. With MAX_PULSES at 3, a byte that needs two pulses and a byte that never takes can both be tested, the second one exhausting the pulse limit. With ACC_CYC at 3, the flash model holds back valid data for two cycles after every address change, so a sequencer that samples too early reads the wrong value.

// File: rtl/mtp_prog_pkg.sv
package mtp_prog_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ER_SETUP,
        S_ER_PULSE,
        S_ER_HOLD,
        S_ER_VFY,
        S_PG_WAIT,
        S_PG_SETUP,
        S_PG_PULSE,
        S_PG_HOLD,
        S_PG_VFY,
        S_ID_RD0,
        S_ID_RD1
    } seq_state_e;

    typedef enum logic {
        OP_JOB   = 1'b0,
        OP_IDENT = 1'b1
    } seq_op_e;

    // Levels of the flash control pins for one sequencer state.
    typedef struct packed {
        logic vpp_hi;
        logic a9_hi;
        logic ce_n;
        logic oe_n;
        logic pgm_n;
    } pin_ctl_t;

    localparam pin_ctl_t PINS_QUIET = '{vpp_hi: 1'b0, a9_hi: 1'b0,
                                        ce_n: 1'b1, oe_n: 1'b1, pgm_n: 1'b1};

    function automatic int unsigned widest(input int unsigned a,
                                           input int unsigned b,
                                           input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Pin levels are a pure decode of the state, so set-up and hold
    // around the strobe come from the SETUP/HOLD states themselves.
    function automatic pin_ctl_t pins_for(input seq_state_e s);
        pin_ctl_t p;
        p = PINS_QUIET;
        case (s)
            S_ER_SETUP, S_ER_HOLD: begin
                p.vpp_hi = 1'b1; p.a9_hi = 1'b1; p.ce_n = 1'b0;
            end
            S_ER_PULSE: begin
                p.vpp_hi = 1'b1; p.a9_hi = 1'b1; p.ce_n = 1'b0; p.pgm_n = 1'b0;
            end
            S_PG_SETUP, S_PG_HOLD: begin
                p.vpp_hi = 1'b1; p.ce_n = 1'b0;
            end
            S_PG_PULSE: begin
                p.vpp_hi = 1'b1; p.ce_n = 1'b0; p.pgm_n = 1'b0;
            end
            S_ER_VFY, S_PG_VFY: begin
                p.ce_n = 1'b0; p.oe_n = 1'b0;
            end
            S_ID_RD0, S_ID_RD1: begin
                p.a9_hi = 1'b1; p.ce_n = 1'b0; p.oe_n = 1'b0;
            end
            default: p = PINS_QUIET;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/mps_timer.sv
// Cycle timer for strobe pulses and read access waits.
module mps_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt_q <= '0;
        else            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q == limit - 1'b1);
endmodule

// File: rtl/mps_addr_walk.sv
// Address walker for the erase read-back sweep.
module mps_addr_walk #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic [AW-1:0] addr,
    output logic          at_end
);
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst || clr) addr_q <= '0;
        else if (inc)   addr_q <= addr_q + 1'b1;
    end

    assign addr   = addr_q;
    assign at_end = &addr_q;
endmodule

// File: rtl/mps_retry.sv
// Counts program pulses spent on the current byte.
module mps_retry #(
    parameter int MAX_PULSES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic spent
);
    localparam int RW = $clog2(MAX_PULSES + 1);
    logic [RW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt_q <= '0;
        else if (inc)   cnt_q <= cnt_q + 1'b1;
    end

    assign spent = (cnt_q == RW'(MAX_PULSES));
endmodule

// File: rtl/mtp_prog_seq.sv
module mtp_prog_seq
    import mtp_prog_pkg::*;
#(
    parameter int AW         = 17,
    parameter int DW         = 8,
    parameter int ERASE_CYC  = 12_500_000,
    parameter int PROG_CYC   = 2_500,
    parameter int ACC_CYC    = 12,
    parameter int MAX_PULSES = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_start,
    input  logic          cmd_op,
    input  logic          img_valid,
    input  logic [AW-1:0] img_addr,
    input  logic [DW-1:0] img_data,
    input  logic          img_last,
    output logic          img_ready,
    output logic          busy,
    output logic          done,
    output logic          erase_fail,
    output logic          prog_fail,
    output logic [AW-1:0] fail_addr,
    output logic [DW-1:0] id_mfr,
    output logic [DW-1:0] id_dev,
    output logic          fl_vpp_hi,
    output logic          fl_a9_hi,
    output logic          fl_ce_n,
    output logic          fl_oe_n,
    output logic          fl_pgm_n,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_dout,
    input  logic [DW-1:0] fl_din
);
    localparam int TW = $clog2(widest(ERASE_CYC, PROG_CYC, ACC_CYC) + 1);
    localparam logic [DW-1:0] ERASED = '1;

    seq_state_e    state_q, state_d;
    pin_ctl_t      pins;
    logic [AW-1:0] pg_addr_q;
    logic [DW-1:0] pg_data_q;
    logic          pg_last_q;
    logic          done_q, efail_q, pfail_q;
    logic [AW-1:0] fail_addr_q;
    logic [DW-1:0] mfr_q, dev_q;

    logic          tmr_clr, tmr_exp;
    logic [TW-1:0] tmr_limit;
    logic          walk_clr, walk_inc, walk_end;
    logic [AW-1:0] walk_addr;
    logic          rty_clr, rty_inc, rty_spent;
    logic          ev_start, ev_accept, ev_efail, ev_pfail, ev_finish, ev_id0, ev_id1;

    mps_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst(rst), .clr(tmr_clr), .limit(tmr_limit), .expired(tmr_exp)
    );

    mps_addr_walk #(.AW(AW)) u_walk (
        .clk(clk), .rst(rst), .clr(walk_clr), .inc(walk_inc),
        .addr(walk_addr), .at_end(walk_end)
    );

    mps_retry #(.MAX_PULSES(MAX_PULSES)) u_retry (
        .clk(clk), .rst(rst), .clr(rty_clr), .inc(rty_inc), .spent(rty_spent)
    );

    always_comb begin
        case (state_q)
            S_ER_PULSE: tmr_limit = TW'(ERASE_CYC);
            S_PG_PULSE: tmr_limit = TW'(PROG_CYC);
            default:    tmr_limit = TW'(ACC_CYC);
        endcase
    end

    always_comb begin
        state_d   = state_q;
        walk_clr  = 1'b0;
        walk_inc  = 1'b0;
        rty_clr   = 1'b0;
        rty_inc   = 1'b0;
        ev_start  = 1'b0;
        ev_accept = 1'b0;
        ev_efail  = 1'b0;
        ev_pfail  = 1'b0;
        ev_finish = 1'b0;
        ev_id0    = 1'b0;
        ev_id1    = 1'b0;
        case (state_q)
            S_IDLE: if (cmd_start) begin
                ev_start = 1'b1;
                walk_clr = 1'b1;
                state_d  = (seq_op_e'(cmd_op) == OP_IDENT) ? S_ID_RD0 : S_ER_SETUP;
            end
            S_ER_SETUP: state_d = S_ER_PULSE;
            S_ER_PULSE: if (tmr_exp) state_d = S_ER_HOLD;
            S_ER_HOLD:  state_d = S_ER_VFY;
            S_ER_VFY: if (tmr_exp) begin
                if (fl_din != ERASED) begin
                    ev_efail  = 1'b1;
                    ev_finish = 1'b1;
                    state_d   = S_IDLE;
                end else if (walk_end) begin
                    state_d = S_PG_WAIT;
                end else begin
                    walk_inc = 1'b1;
                end
            end
            S_PG_WAIT: if (img_valid) begin
                ev_accept = 1'b1;
                rty_clr   = 1'b1;
                state_d   = S_PG_SETUP;
            end
            S_PG_SETUP: state_d = S_PG_PULSE;
            S_PG_PULSE: if (tmr_exp) begin
                rty_inc = 1'b1;
                state_d = S_PG_HOLD;
            end
            S_PG_HOLD: state_d = S_PG_VFY;
            S_PG_VFY: if (tmr_exp) begin
                if (fl_din == pg_data_q) begin
                    if (pg_last_q) begin
                        ev_finish = 1'b1;
                        state_d   = S_IDLE;
                    end else begin
                        state_d = S_PG_WAIT;
                    end
                end else if (rty_spent) begin
                    ev_pfail  = 1'b1;
                    ev_finish = 1'b1;
                    state_d   = S_IDLE;
                end else begin
                    state_d = S_PG_SETUP;
                end
            end
            S_ID_RD0: if (tmr_exp) begin
                ev_id0  = 1'b1;
                state_d = S_ID_RD1;
            end
            S_ID_RD1: if (tmr_exp) begin
                ev_id1    = 1'b1;
                ev_finish = 1'b1;
                state_d   = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // A new address inside the sweep restarts the access wait as well.
    assign tmr_clr = (state_d != state_q) || walk_inc;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= S_IDLE;
            pg_addr_q   <= '0;
            pg_data_q   <= '0;
            pg_last_q   <= 1'b0;
            done_q      <= 1'b0;
            efail_q     <= 1'b0;
            pfail_q     <= 1'b0;
            fail_addr_q <= '0;
            mfr_q       <= '0;
            dev_q       <= '0;
        end else begin
            state_q <= state_d;
            if (ev_start) begin
                done_q      <= 1'b0;
                efail_q     <= 1'b0;
                pfail_q     <= 1'b0;
                fail_addr_q <= '0;
            end
            if (ev_accept) begin
                pg_addr_q <= img_addr;
                pg_data_q <= img_data;
                pg_last_q <= img_last;
            end
            if (ev_efail) begin
                efail_q     <= 1'b1;
                fail_addr_q <= walk_addr;
            end
            if (ev_pfail) begin
                pfail_q     <= 1'b1;
                fail_addr_q <= pg_addr_q;
            end
            if (ev_finish) done_q <= 1'b1;
            if (ev_id0)    mfr_q  <= fl_din;
            if (ev_id1)    dev_q  <= fl_din;
        end
    end

    assign pins      = pins_for(state_q);
    assign fl_vpp_hi = pins.vpp_hi;
    assign fl_a9_hi  = pins.a9_hi;
    assign fl_ce_n   = pins.ce_n;
    assign fl_oe_n   = pins.oe_n;
    assign fl_pgm_n  = pins.pgm_n;

    always_comb begin
        case (state_q)
            S_ER_VFY:  fl_addr = walk_addr;
            S_ID_RD0:  fl_addr = '0;
            S_ID_RD1:  fl_addr = AW'(1);
            S_PG_SETUP, S_PG_PULSE, S_PG_HOLD, S_PG_VFY: fl_addr = pg_addr_q;
            default:   fl_addr = '0;
        endcase
    end

    assign fl_dout    = pg_data_q;
    assign img_ready  = (state_q == S_PG_WAIT);
    assign busy       = (state_q != S_IDLE);
    assign done       = done_q;
    assign erase_fail = efail_q;
    assign prog_fail  = pfail_q;
    assign fail_addr  = fail_addr_q;
    assign id_mfr     = mfr_q;
    assign id_dev     = dev_q;
endmodule

// File: rtl/mtp_prog_seq_chk.sv
module mtp_prog_seq_chk #(
    parameter int AW = 17,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          done,
    input logic          erase_fail,
    input logic          prog_fail,
    input logic          img_ready,
    input logic          fl_vpp_hi,
    input logic          fl_ce_n,
    input logic          fl_oe_n,
    input logic          fl_pgm_n,
    input logic [AW-1:0] fl_addr,
    input logic [DW-1:0] fl_dout
);
    p_strobe_ctx_r6: assert property (@(posedge clk) disable iff (rst)
        !fl_pgm_n |-> (!fl_ce_n && fl_oe_n && fl_vpp_hi));

    p_setup_before_fall_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(fl_pgm_n) |-> ($past(fl_vpp_hi) && !$past(fl_ce_n) && $past(fl_oe_n)));

    p_hold_after_rise_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(fl_pgm_n) |-> (fl_vpp_hi && !fl_ce_n && fl_oe_n));

    p_stable_in_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        (!fl_pgm_n && $past(!fl_pgm_n)) |-> ($stable(fl_addr) && $stable(fl_dout)));

    p_read_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !fl_oe_n |-> (fl_pgm_n && !fl_vpp_hi));

    p_ready_in_job_r5: assert property (@(posedge clk) disable iff (rst)
        img_ready |-> (busy && !done));

    p_fail_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(erase_fail && prog_fail));

    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

bind mtp_prog_seq mtp_prog_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done),
    .erase_fail(erase_fail), .prog_fail(prog_fail), .img_ready(img_ready),
    .fl_vpp_hi(fl_vpp_hi), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n),
    .fl_pgm_n(fl_pgm_n), .fl_addr(fl_addr), .fl_dout(fl_dout)
);

// File: tb/mtp_prog_seq_bench.sv
module mtp_prog_seq_bench;
    localparam int AW = 4, DW = 8, ERASE_CYC = 24, PROG_CYC = 6, ACC_CYC = 3, MAX_PULSES = 3;
    localparam int NB = 1 << AW;
    localparam logic [7:0] ID_A = 8'h3C, ID_B = 8'hC5;

    logic clk = 1'b0, rst = 1'b1;
    logic cmd_start = 1'b0, cmd_op = 1'b0;
    logic img_valid = 1'b0, img_last = 1'b0;
    logic [AW-1:0] img_addr = '0;
    logic [DW-1:0] img_data = '0;
    logic img_ready, busy, done, erase_fail, prog_fail;
    logic [AW-1:0] fail_addr, fl_addr;
    logic [DW-1:0] id_mfr, id_dev, fl_dout, fl_din;
    logic fl_vpp_hi, fl_a9_hi, fl_ce_n, fl_oe_n, fl_pgm_n;

    int total = 0, bad = 0;

    always #4 clk = ~clk;

    mtp_prog_seq #(.AW(AW), .DW(DW), .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC),
                   .ACC_CYC(ACC_CYC), .MAX_PULSES(MAX_PULSES)) u_mtp_prog_seq (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_op(cmd_op),
        .img_valid(img_valid), .img_addr(img_addr), .img_data(img_data),
        .img_last(img_last), .img_ready(img_ready), .busy(busy), .done(done),
        .erase_fail(erase_fail), .prog_fail(prog_fail), .fail_addr(fail_addr),
        .id_mfr(id_mfr), .id_dev(id_dev), .fl_vpp_hi(fl_vpp_hi), .fl_a9_hi(fl_a9_hi),
        .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_pgm_n(fl_pgm_n),
        .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_din(fl_din)
    );

    // ---------------- flash model ----------------
    logic          stuck_en = 1'b0, weak_en = 1'b0;
    logic [AW-1:0] stuck_at = '0, weak_at = '0;
    int            weak_need = 0;

    logic [7:0]    mem [NB];
    int            pulses_at [NB];
    int            run, plen, er_cnt, pg_cnt, len_err, setup_err;
    logic [NB-1:0] rd_mask;
    logic [1:0]    id_mask;
    logic [AW-1:0] addr_q;
    logic          any_ready, early_ready;
    logic          pv_q, pce_q, poe_q;
    int            cur_idx;

    always_comb begin
        if (!fl_ce_n && !fl_oe_n)
            cur_idx = (fl_addr == addr_q && run != 0) ? run + 1 : 1;
        else
            cur_idx = 0;
        if (cur_idx >= ACC_CYC)
            fl_din = fl_a9_hi ? (fl_addr[0] ? ID_B : ID_A) : mem[fl_addr];
        else
            fl_din = 8'h5A;
    end

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NB; i++) begin
                mem[i] <= 8'(i * 37);
                pulses_at[i] <= 0;
            end
            run <= 0; plen <= 0; er_cnt <= 0; pg_cnt <= 0; len_err <= 0; setup_err <= 0;
            rd_mask <= '0; id_mask <= '0; addr_q <= '0; any_ready <= 1'b0;
            early_ready <= 1'b0; pv_q <= 1'b0; pce_q <= 1'b1; poe_q <= 1'b1;
        end else begin
            run <= cur_idx;
            addr_q <= fl_addr;
            pv_q <= fl_vpp_hi; pce_q <= fl_ce_n; poe_q <= fl_oe_n;
            if (cur_idx >= ACC_CYC) begin
                if (fl_a9_hi) id_mask[fl_addr[0]] <= 1'b1;
                else          rd_mask[fl_addr] <= 1'b1;
            end
            if (img_ready) begin
                any_ready <= 1'b1;
                if (rd_mask != '1) early_ready <= 1'b1;
            end
            if (!fl_pgm_n) begin
                if (plen == 0 && (!pv_q || pce_q || !poe_q)) setup_err <= setup_err + 1;
                plen <= plen + 1;
            end else if (plen != 0) begin
                plen <= 0;
                if (!fl_vpp_hi || fl_ce_n || !fl_oe_n) setup_err <= setup_err + 1;
                if (fl_a9_hi) begin
                    er_cnt <= er_cnt + 1;
                    if (plen != ERASE_CYC) len_err <= len_err + 1;
                    for (int i = 0; i < NB; i++)
                        mem[i] <= (stuck_en && AW'(i) == stuck_at) ? 8'hEF : 8'hFF;
                end else begin
                    pg_cnt <= pg_cnt + 1;
                    if (plen != PROG_CYC) len_err <= len_err + 1;
                    pulses_at[fl_addr] <= pulses_at[fl_addr] + 1;
                    if (!(weak_en && fl_addr == weak_at && pulses_at[fl_addr] + 1 < weak_need))
                        mem[fl_addr] <= mem[fl_addr] & fl_dout;
                end
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; cmd_start = 1'b0; img_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic start_cmd(input logic op);
        cmd_op = op; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic send_byte(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic last);
        int guard = 0;
        img_addr = a; img_data = d; img_last = last; img_valid = 1'b1;
        while (!img_ready && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        img_valid = 1'b0; img_last = 1'b0;
    endtask

    task automatic wait_done();
        int guard = 0;
        while (!done && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        do_reset();
        chk("R1 busy", busy, 0);
        chk("R1 done/fails/ready", {done, erase_fail, prog_fail, img_ready}, 4'b0000);
        chk("R1 strobes", {fl_ce_n, fl_oe_n, fl_pgm_n}, 3'b111);
        chk("R1 hv flags", {fl_vpp_hi, fl_a9_hi}, 2'b00);
    endtask

    task automatic t_job_ok();
        logic [7:0] exp [NB];
        int miss = 0;
        do_reset();
        start_cmd(1'b0);
        repeat (4) @(negedge clk);
        start_cmd(1'b1);                       // R11: ignored while busy
        send_byte(4'd2, 8'hA5, 1'b0);
        send_byte(4'd3, 8'h3C, 1'b0);
        send_byte(4'd7, 8'h00, 1'b0);
        send_byte(4'd15, 8'h81, 1'b1);
        wait_done();
        for (int i = 0; i < NB; i++) exp[i] = 8'hFF;
        exp[2] = 8'hA5; exp[3] = 8'h3C; exp[7] = 8'h00; exp[15] = 8'h81;
        for (int i = 0; i < NB; i++) if (mem[i] != exp[i]) miss++;
        chk("R2 one erase pulse", er_cnt, 1);
        chk("R2 R6 pulse lengths", len_err, 0);
        chk("R7 setup/hold", setup_err, 0);
        chk("R3 all addresses read", rd_mask, 16'hFFFF);
        chk("R3 ready held until verified", early_ready, 0);
        chk("R6 image bytes written", miss, 0);
        chk("R8 one pulse per good byte", pg_cnt, 4);
        chk("R9 done/busy/fails", {done, busy, erase_fail, prog_fail}, 4'b1000);
        chk("R11 identify ignored", {id_mask, id_mfr}, 10'h0);
    endtask

    task automatic t_erase_fail();
        stuck_en = 1'b1; stuck_at = 4'd9;
        do_reset();
        start_cmd(1'b0);
        wait_done();
        chk("R4 erase_fail/prog_fail", {erase_fail, prog_fail}, 2'b10);
        chk("R4 fail_addr", fail_addr, 9);
        chk("R4 no program pulse", pg_cnt, 0);
        chk("R4 sweep stops at fault", rd_mask, 16'h03FF);
        chk("R5 ready never raised", any_ready, 0);
        stuck_en = 1'b0;
    endtask

    task automatic t_retry();
        weak_en = 1'b1; weak_at = 4'd4; weak_need = 2;
        do_reset();
        start_cmd(1'b0);
        send_byte(4'd4, 8'h12, 1'b1);
        wait_done();
        chk("R8 retry pulses", pulses_at[4], 2);
        chk("R8 retried byte value", mem[4], 8'h12);
        chk("R9 success after retry", {done, erase_fail, prog_fail}, 3'b100);
        weak_en = 1'b0;
    endtask

    task automatic t_prog_fail();
        weak_en = 1'b1; weak_at = 4'd6; weak_need = 9;
        do_reset();
        start_cmd(1'b0);
        send_byte(4'd1, 8'h55, 1'b0);
        send_byte(4'd6, 8'h0F, 1'b1);
        wait_done();
        chk("R8 prog_fail raised", {done, erase_fail, prog_fail}, 3'b101);
        chk("R8 fail_addr", fail_addr, 6);
        chk("R8 pulse limit", pulses_at[6], MAX_PULSES);
        chk("R8 earlier byte kept", mem[1], 8'h55);
        weak_en = 1'b0;
    endtask

    task automatic t_ident();
        do_reset();
        start_cmd(1'b1);
        wait_done();
        chk("R10 id_mfr", id_mfr, ID_A);
        chk("R10 id_dev", id_dev, ID_B);
        chk("R10 both id addresses read", id_mask, 2'b11);
        chk("R10 no strobe", er_cnt + pg_cnt, 0);
        chk("R10 done", {done, busy}, 2'b10);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_job_ok();
        t_erase_fail();
        t_retry();
        t_prog_fail();
        t_ident();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule